// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Function Multiplexing

This block is one general-purpose I/O port of sixteen pins. Software programs it through a simple register read/write port. Each pin is either a plain GPIO or is handed to one of four peripheral functions.

In GPIO mode the pin is driven from an output data latch and a direction latch. Both latches have write-one-to-set and write-one-to-clear aliases, so one bit can change without a read-modify-write. In peripheral mode the pin's drive value and drive enable come from the chosen function's signal vectors.

Incoming pad levels pass through a two-flop synchroniser and then through a per-pin input-enable gate. The gated levels go to a pin-interrupt block and are also visible through the data read-back.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every register is zero, so all pins are GPIO inputs with input buffers off: `pad_oe`, `pin_level` and every register read return 0.
- R2: A write to the data-set alias (address 0x3) sets each data-latch bit written as 1 and leaves bits written as 0 unchanged. Reading address 0x3 returns the data latch.
- R3: A write to the data-clear alias (address 0x4) clears each data-latch bit written as 1 and leaves the other bits unchanged. Reading address 0x4 returns the data latch.
- R4: The direction latch behaves the same way: set alias at 0x6, clear alias at 0x7, plain write and read at 0x5. A direction bit of 1 means the pin is an output.
- R5: When a pin's function-enable bit (address 0x0) is 0, `pad_oe` equals its direction bit and `pad_out` equals its data-latch bit. A plain write to address 0x2 loads the data latch.
- R6: When a pin's function-enable bit is 1, the 2-bit field at bits [2n+1:2n] of the mux register (address 0x1) selects function f. Pin n then drives `pad_out` from `fn_dout[f*16+n]` and `pad_oe` from `fn_oe[f*16+n]`.
- R7: With input enable set (address 0x8), `pin_level[n]` shows `pad_in[n]` two clock edges after that level is presented.
- R8: With input enable clear, `pin_level[n]` is 0. Reading address 0x2 returns 0 for that pin when it is an input.
- R9: Reading address 0x2 returns the data-latch bit for pins whose direction is output, and the gated input level for input pins.
- R10: The function-enable, mux, direction and input-enable registers read back the value last written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 16 | Raw pad input levels |
| pad_out | output | 16 | Pad drive values |
| pad_oe | output | 16 | Pad drive enables |
| fn_dout | input | 64 | Peripheral drive values, function f at bits [f*16+15:f*16] |
| fn_oe | input | 64 | Peripheral drive enables, same layout |
| pin_level | output | 16 | Synchronised, input-enable-gated pin levels for the interrupt block |

## Verification
The set and clear aliases are driven with overlapping and disjoint bit patterns, so that write-one semantics can be told apart from a plain load. The mux field is written with a different function per pin, against peripheral vectors that differ by function. A swapped field or a wrong index then shows on a specific pin. Pad input patterns change while input enable is partly set, which separates the two-cycle latency from gating faults. Read-back of address 0x2 is tried with a mix of output and input pins. A behavioural model is compared on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;

  typedef enum logic [ADDR_W-1:0] {
    RA_FEN    = 4'h0,
    RA_MUX    = 4'h1,
    RA_DATA   = 4'h2,
    RA_DSET   = 4'h3,
    RA_DCLR   = 4'h4,
    RA_DIR    = 4'h5,
    RA_DIRSET = 4'h6,
    RA_DIRCLR = 4'h7,
    RA_INEN   = 4'h8
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BUS_W-1:0]       wdata,
  input  logic [NPINS-1:0]       pin_state,
  output logic [NPINS-1:0]       fen_q,
  output logic [NPINS*SEL_W-1:0] mux_q,
  output logic [NPINS-1:0]       data_q,
  output logic [NPINS-1:0]       dir_q,
  output logic [NPINS-1:0]       inen_q,
  output logic [BUS_W-1:0]       rdata
);
  localparam int MUX_W = NPINS * SEL_W;

  function automatic logic [NPINS-1:0] w1_apply(input logic [NPINS-1:0] cur,
                                                input logic [NPINS-1:0] bits,
                                                input logic             set);
    return set ? (cur | bits) : (cur & ~bits);
  endfunction

  function automatic logic [BUS_W-1:0] widen(input logic [NPINS-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  logic [NPINS-1:0] wbits;
  assign wbits = wdata[NPINS-1:0];

  logic wr_fen, wr_mux, wr_data, wr_dset, wr_dclr, wr_dir, wr_dirset, wr_dirclr, wr_inen;
  assign wr_fen    = wr && (addr == RA_FEN);
  assign wr_mux    = wr && (addr == RA_MUX);
  assign wr_data   = wr && (addr == RA_DATA);
  assign wr_dset   = wr && (addr == RA_DSET);
  assign wr_dclr   = wr && (addr == RA_DCLR);
  assign wr_dir    = wr && (addr == RA_DIR);
  assign wr_dirset = wr && (addr == RA_DIRSET);
  assign wr_dirclr = wr && (addr == RA_DIRCLR);
  assign wr_inen   = wr && (addr == RA_INEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fen_q  <= '0;
      mux_q  <= '0;
      data_q <= '0;
      dir_q  <= '0;
      inen_q <= '0;
    end else begin
      if (wr_fen)  fen_q  <= wbits;
      if (wr_mux)  mux_q  <= wdata[MUX_W-1:0];
      if (wr_inen) inen_q <= wbits;
      if (wr_data)      data_q <= wbits;
      else if (wr_dset) data_q <= w1_apply(data_q, wbits, 1'b1);
      else if (wr_dclr) data_q <= w1_apply(data_q, wbits, 1'b0);
      if (wr_dir)         dir_q <= wbits;
      else if (wr_dirset) dir_q <= w1_apply(dir_q, wbits, 1'b1);
      else if (wr_dirclr) dir_q <= w1_apply(dir_q, wbits, 1'b0);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_FEN:                         rdata = widen(fen_q);
      RA_MUX:                         rdata[MUX_W-1:0] = mux_q;
      RA_DATA:                        rdata = widen(pin_state);
      RA_DSET, RA_DCLR:               rdata = widen(data_q);
      RA_DIR, RA_DIRSET, RA_DIRCLR:   rdata = widen(dir_q);
      RA_INEN:                        rdata = widen(inen_q);
      default:                        rdata = '0;
    endcase
  end

  // R2: written ones become set, zeros keep their value
  p_set_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dset |=> ((data_q & $past(wbits)) == $past(wbits)) &&
                ((data_q & ~$past(wbits)) == ($past(data_q) & ~$past(wbits))));
  // R3: written ones become clear, zeros keep their value
  p_clr_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dclr |=> ((data_q & $past(wbits)) == '0) &&
                ((data_q & ~$past(wbits)) == ($past(data_q) & ~$past(wbits))));
  // R4: direction aliases
  p_dirset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dirset |=> ((dir_q & $past(wbits)) == $past(wbits)));
  p_dirclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dirclr |=> ((dir_q & $past(wbits)) == '0));
  // R10: plain registers hold the written value
  p_fen_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fen |=> (fen_q == $past(wbits)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int NPINS = 16,
  parameter int NFUNC = 4,
  parameter int SEL_W = 2
) (
  input  logic [NPINS-1:0]       fen,
  input  logic [NPINS*SEL_W-1:0] mux,
  input  logic [NPINS-1:0]       gpio_data,
  input  logic [NPINS-1:0]       gpio_dir,
  input  logic [NFUNC*NPINS-1:0] fn_dout,
  input  logic [NFUNC*NPINS-1:0] fn_oe,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_oe
);
  function automatic logic pick(input logic [NFUNC*NPINS-1:0] v,
                                input logic [SEL_W-1:0]       sel,
                                input int                     pin);
    int idx;
    idx = int'(sel) * NPINS + pin;
    return (idx < NFUNC * NPINS) ? v[idx] : 1'b0;
  endfunction

  generate
    for (genvar n = 0; n < NPINS; n++) begin : g_pin
      logic [SEL_W-1:0] sel;
      assign sel = mux[n*SEL_W +: SEL_W];
      always_comb begin
        if (fen[n]) begin
          pad_out[n] = pick(fn_dout, sel, n);
          pad_oe[n]  = pick(fn_oe, sel, n);
        end else begin
          pad_out[n] = gpio_data[n];
          pad_oe[n]  = gpio_dir[n];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int NFUNC       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [BUS_W-1:0]       bus_wdata,
  output logic [BUS_W-1:0]       bus_rdata,
  input  logic [NPINS-1:0]       pad_in,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_oe,
  input  logic [NFUNC*NPINS-1:0] fn_dout,
  input  logic [NFUNC*NPINS-1:0] fn_oe,
  output logic [NPINS-1:0]       pin_level
);
  localparam int SEL_W = $clog2(NFUNC);

  function automatic logic [NPINS-1:0] readback(input logic [NPINS-1:0] dir,
                                                input logic [NPINS-1:0] latch,
                                                input logic [NPINS-1:0] lvl);
    return (dir & latch) | (~dir & lvl);
  endfunction

  logic [NPINS-1:0]       fen_q, data_q, dir_q, inen_q, sync_q, pin_state;
  logic [NPINS*SEL_W-1:0] mux_q;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
  );

  assign pin_level = sync_q & inen_q;
  assign pin_state = readback(dir_q, data_q, pin_level);

  gpio_regfile #(.NPINS(NPINS), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pin_state(pin_state), .fen_q(fen_q), .mux_q(mux_q), .data_q(data_q),
    .dir_q(dir_q), .inen_q(inen_q), .rdata(bus_rdata)
  );

  gpio_pin_mux #(.NPINS(NPINS), .NFUNC(NFUNC), .SEL_W(SEL_W)) u_mux (
    .fen(fen_q), .mux(mux_q), .gpio_data(data_q), .gpio_dir(dir_q),
    .fn_dout(fn_dout), .fn_oe(fn_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // R5: a set-alias write shows on GPIO-mode pads one cycle later
  p_gpio_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_DSET) |=>
      ((pad_out & ~fen_q & $past(bus_wdata[NPINS-1:0])) ==
       (~fen_q & $past(bus_wdata[NPINS-1:0]))));
  // R8: a pin with input enable cleared forwards no level
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_INEN) |=>
      ((pin_level & ~$past(bus_wdata[NPINS-1:0])) == '0));
endmodule

// File: tb/gpio_port_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_port_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe, pin_level;
  logic [63:0] fn_dout = '0;
  logic [63:0] fn_oe = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  gpio_port_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .fn_dout(fn_dout), .fn_oe(fn_oe),
    .pin_level(pin_level)
  );

  // behavioural reference
  logic [15:0] m_fen, m_data, m_dir, m_inen;
  logic [31:0] m_mux;
  logic [15:0] m_hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fen = 0; m_data = 0; m_dir = 0; m_inen = 0; m_mux = 0;
      m_hist.delete();
    end else begin
      m_hist.push_back(pad_in);
      if (m_hist.size() > 2) void'(m_hist.pop_front());
      if (bus_wr) begin
        case (bus_addr)
          0: m_fen  = bus_wdata[15:0];
          1: m_mux  = bus_wdata;
          2: m_data = bus_wdata[15:0];
          3: m_data = m_data | bus_wdata[15:0];
          4: m_data = m_data & ~bus_wdata[15:0];
          5: m_dir  = bus_wdata[15:0];
          6: m_dir  = m_dir | bus_wdata[15:0];
          7: m_dir  = m_dir & ~bus_wdata[15:0];
          8: m_inen = bus_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] exp_level();
    logic [15:0] raw;
    raw = (m_hist.size() == 2) ? m_hist[0] : 16'h0;
    return raw & m_inen;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [3:0] a);
    logic [15:0] st;
    for (int n = 0; n < 16; n++) st[n] = m_dir[n] ? m_data[n] : exp_level()[n];
    case (a)
      0: return {16'h0, m_fen};
      1: return m_mux;
      2: return {16'h0, st};
      3, 4: return {16'h0, m_data};
      5, 6, 7: return {16'h0, m_dir};
      8: return {16'h0, m_inen};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] exp_pad(input bit want_oe);
    logic [15:0] r;
    for (int n = 0; n < 16; n++) begin
      int f;
      f = (m_mux >> (2 * n)) & 3;
      if (m_fen[n]) r[n] = want_oe ? fn_oe[f*16+n] : fn_dout[f*16+n];
      else          r[n] = want_oe ? m_dir[n] : m_data[n];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // lockstep comparison every cycle
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R5/R6 pad_out", {16'h0, pad_out}, {16'h0, exp_pad(0)});
      chk("R5/R6 pad_oe", {16'h0, pad_oe}, {16'h0, exp_pad(1)});
      chk("R7 pin_level", {16'h0, pin_level}, {16'h0, exp_level()});
      chk("R10 rdata", bus_rdata, exp_rdata(bus_addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [15:0] fvec(input int f);
    return 16'h0F0F ^ (16'h1357 * (f + 1));
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] mx;
    logic [15:0] expo;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk); #1;
    chk("R1 pad_oe", {16'h0, pad_oe}, 0);
    chk("R1 pin_level", {16'h0, pin_level}, 0);
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], v);
      chk("R1 rdata", v, 0);
    end
    // R2
    wr(3, 32'hFFFF_00F0); rd(3, v); chk("R2 set", v, 32'h00F0);
    wr(3, 32'h0000_0003); rd(3, v); chk("R2 zeros unchanged", v, 32'h00F3);
    // R3
    wr(4, 32'h0000_0030); rd(4, v); chk("R3 clear", v, 32'h00C3);
    // R4
    wr(6, 32'h0000_FF00); wr(7, 32'h0000_0F00); rd(5, v); chk("R4 dir aliases", v, 32'hF000);
    wr(5, 32'h0000_F001); wr(7, 32'h1); rd(6, v); chk("R4 plain dir", v, 32'hF000);
    // R5
    wr(2, 32'h0000_A5C3);
    @(negedge clk); #1;
    chk("R5 pad_oe", {16'h0, pad_oe}, 32'hF000);
    chk("R5 pad_out", {16'h0, pad_out}, 32'hA5C3);
    // R8 / R9
    pad_in = 16'h0FFF;
    repeat (3) @(negedge clk);
    rd(2, v); chk("R8 R9 disabled input reads 0", v, 32'hA000);
    chk("R8 pin_level gated", {16'h0, pin_level}, 0);
    // R7
    wr(8, 32'h0000_00FF);
    @(negedge clk); #1;
    chk("R7 level enabled", {16'h0, pin_level}, 32'h00FF);
    rd(2, v); chk("R9 mixed readback", v, 32'hA0FF);
    @(negedge clk); pad_in = 16'h0F0F;
    @(negedge clk); #1; chk("R7 one edge later unchanged", {16'h0, pin_level}, 32'h00FF);
    @(negedge clk); #1; chk("R7 two edges later", {16'h0, pin_level}, 32'h000F);
    // R6
    for (int f = 0; f < 4; f++) begin
      fn_dout[f*16 +: 16] = fvec(f);
      fn_oe[f*16 +: 16]   = ~fvec(f);
    end
    mx = 0;
    for (int n = 0; n < 16; n++) mx[2*n +: 2] = (n * 3 + 1) % 4;
    wr(1, mx);
    wr(0, 32'h0000_00FF);
    @(negedge clk); #1;
    expo = 16'hA500;
    for (int n = 0; n < 8; n++) expo[n] = fvec((n * 3 + 1) % 4)[n];
    chk("R6 partial peripheral pad_out", {16'h0, pad_out}, {16'h0, expo});
    wr(0, 32'h0000_FFFF);
    @(negedge clk); #1;
    for (int n = 0; n < 16; n++) expo[n] = ~fvec((n * 3 + 1) % 4)[n];
    chk("R6 all peripheral pad_oe", {16'h0, pad_oe}, {16'h0, expo});
    // R10
    rd(0, v); chk("R10 fen readback", v, 32'hFFFF);
    rd(1, v); chk("R10 mux readback", v, mx);
    rd(8, v); chk("R10 inen readback", v, 32'h00FF);
    rd(4'hC, v); chk("R10 unmapped", v, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule